// File: doc/BRIEF.md
# Variable-Rate Sample Request Scheduler

This block sits in the digital link logic of an audio codec. The serial link carries one frame every 1/48000 s. Once per frame, the block decides two things. First, whether the codec asks the controller for a fresh playback sample pair in the next frame. Second, whether the codec has a fresh capture sample pair to send in the current frame. Playback and capture each have their own 16-bit rate register, which holds a rate in hertz. A single enable bit switches the pair between variable-rate pacing and fixed full-rate operation.

Pacing uses one fractional accumulator per path. On each frame strobe the path adds its rate to the accumulator. When the sum reaches the frame rate, the path fires for that frame and the frame rate is subtracted from the sum. The result is an evenly spread pattern of exactly `rate` requests per 48000 frames.

The playback decision leaves the block as two active-low slot flags, one for the left sample and one for the right. They are meant for the request-bit positions of the outgoing status-address slot, which the serializer outside this block drives. The capture decision leaves as a one-cycle strobe.

Top module: `rate_req_sched`

## Requirements
- R1: After reset both rate registers hold 48000 (0xBB80), both request flags are 1 and `cap_valid` is 0. With these defaults and variable rate enabled, every frame strobe fires both paths.
- R2: On a frame strobe with variable rate enabled, the playback path forms sum = accumulator + rate. If sum >= 48000, the request flags go to 0 and the accumulator becomes sum - 48000. Otherwise the flags go to 1 and the accumulator becomes sum. The flags change in the clock cycle after the strobe and hold until the next strobe.
- R3: `req_left_n` (meant for status-address bit 11) and `req_right_n` (meant for bit 10) are active-low and always carry the same value. 0 means the controller must send that sample next frame; 1 means it must leave that slot empty.
- R4: The capture path paces with the same rule on its own rate register and its own accumulator. `cap_valid` is 1 for exactly the one cycle after a strobe on which the capture path fires, and 0 in every other cycle.
- R5: A rate written below 4000 is stored as 4000. A written 100 therefore fires once every 12 frames.
- R6: A rate written above 48000 is stored as 48000, so the path fires on every frame.
- R7: While `vra_en` is 0, every strobe fires both paths and both accumulators are held at zero, whatever the rate registers hold. Rate writes are still stored.
- R8: Writing a rate register clears that path's accumulator only. When a write and a strobe fall in the same cycle, the decision for that frame uses the rate and accumulator from before the write, and the accumulator then becomes zero.
- R9: Starting from a cleared accumulator at rate r, the number of firings over the first N strobes equals floor(N*r/48000). For example, 11025 Hz gives 110 firings in 480 frames, and 44100 Hz gives 441.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse, once per 48 kHz frame |
| vra_en | input | 1 | 1 = paced by rate registers, 0 = fixed full rate |
| play_rate_wr | input | 1 | Write strobe for the playback rate |
| play_rate_in | input | 16 | Playback rate in hertz |
| cap_rate_wr | input | 1 | Write strobe for the capture rate |
| cap_rate_in | input | 16 | Capture rate in hertz |
| req_left_n | output | 1 | Active-low left playback request flag |
| req_right_n | output | 1 | Active-low right playback request flag |
| cap_valid | output | 1 | One-cycle capture-sample-valid strobe |

## Verification
A wrong accumulator value is visible only through the timing of the firings. It shows up as a request or capture strobe on the wrong frame, usually within the next few frame strobes. The exception is a rate near 4000, where the error may take up to 12 frames to appear. A missed clear on write, or a lost hold during fixed-rate mode, shifts the whole firing pattern from that point on. A count over a long run exposes a rate that is stored or clamped wrongly, even where individual frames happen to line up. The bench therefore compares every frame's flags and strobe against its own accumulator model, and it also checks long-run firing counts against the floor formula.

// File: rtl/rate_req_sched.sv
module rate_req_sched #(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int MIN_HZ   = 4000,
  parameter int RESET_HZ = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              vra_en,
  input  logic              play_rate_wr,
  input  logic [RATE_W-1:0] play_rate_in,
  input  logic              cap_rate_wr,
  input  logic [RATE_W-1:0] cap_rate_in,
  output logic              req_left_n,
  output logic              req_right_n,
  output logic              cap_valid
);

  localparam int NPATH = 2;
  localparam int ACC_W = $clog2(2 * FRAME_HZ);
  localparam logic [RATE_W-1:0] MIN_R   = RATE_W'(MIN_HZ);
  localparam logic [RATE_W-1:0] MAX_R   = RATE_W'(FRAME_HZ);
  localparam logic [RATE_W-1:0] RST_R   = RATE_W'(RESET_HZ);
  localparam logic [ACC_W-1:0]  FRAME_A = ACC_W'(FRAME_HZ);

  logic [NPATH-1:0]             wr;
  logic [NPATH-1:0][RATE_W-1:0] wdata;
  logic [NPATH-1:0][RATE_W-1:0] rate_q;
  logic [NPATH-1:0][ACC_W-1:0]  acc_q;
  logic [NPATH-1:0]             fire;
  logic                         req_n_q;

  assign wr    = {cap_rate_wr, play_rate_wr};
  assign wdata = {cap_rate_in, play_rate_in};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [RATE_W-1:0] clamped;
    logic [ACC_W-1:0]  sum;

    assign clamped = (wdata[p] < MIN_R) ? MIN_R :
                     (wdata[p] > MAX_R) ? MAX_R : wdata[p];
    assign sum     = acc_q[p] + ACC_W'(rate_q[p]);
    assign fire[p] = !vra_en || (sum >= FRAME_A);

    always_ff @(posedge clk) begin
      if (!rst_n)        rate_q[p] <= RST_R;
      else if (wr[p])    rate_q[p] <= clamped;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || wr[p] || !vra_en) acc_q[p] <= '0;
      else if (frame_tick)            acc_q[p] <= fire[p] ? sum - FRAME_A : sum;
    end

    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[p] < FRAME_A);
    p_rate_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q[p] >= MIN_R) && (rate_q[p] <= MAX_R));
    p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr[p] |=> (acc_q[p] == '0));
    p_fixed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vra_en |=> (acc_q[p] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_n_q   <= 1'b1;
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= frame_tick && fire[1];
      if (frame_tick) req_n_q <= !fire[0];
    end
  end

  assign req_left_n  = req_n_q;
  assign req_right_n = req_n_q;

  p_fixed_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !vra_en) |=> (!req_left_n && cap_valid));
  p_cap_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> $past(frame_tick));
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(req_left_n));
  p_full_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !play_rate_wr && rate_q[0] == MAX_R) |=> !req_left_n);

endmodule

// File: tb/sim_rate_req_sched.sv
module sim_rate_req_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, vra_en = 1'b1;
  logic play_rate_wr = 1'b0, cap_rate_wr = 1'b0;
  logic [15:0] play_rate_in = '0, cap_rate_in = '0;
  logic req_left_n, req_right_n, cap_valid;

  int checks = 0, failures = 0;
  int m_acc [2];
  int m_rate [2];
  bit m_req_n;
  bit done = 0;

  always #4 clk = ~clk;

  rate_req_sched u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .vra_en(vra_en),
    .play_rate_wr(play_rate_wr), .play_rate_in(play_rate_in),
    .cap_rate_wr(cap_rate_wr), .cap_rate_in(cap_rate_in),
    .req_left_n(req_left_n), .req_right_n(req_right_n), .cap_valid(cap_valid));

  function automatic int clampr(int v);
    return (v < 4000) ? 4000 : (v > 48000) ? 48000 : v;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock step starting and ending at a falling edge
  task automatic step(bit tk, bit wp, bit wc, int dp, int dc, string tag,
                      output bit fp, output bit fc);
    bit f [2];
    frame_tick = tk; play_rate_wr = wp; cap_rate_wr = wc;
    play_rate_in = 16'(dp); cap_rate_in = 16'(dc);
    for (int p = 0; p < 2; p++) begin
      int s = m_acc[p] + m_rate[p];
      f[p] = !vra_en || (s >= 48000);
      if (tk) m_acc[p] = vra_en ? (f[p] ? s - 48000 : s) : 0;
      if (!vra_en) m_acc[p] = 0;
    end
    if (wp) begin m_rate[0] = clampr(dp); m_acc[0] = 0; end
    if (wc) begin m_rate[1] = clampr(dc); m_acc[1] = 0; end
    if (tk) m_req_n = !f[0];
    fp = tk && f[0];
    fc = tk && f[1];
    @(negedge clk);
    frame_tick = 0; play_rate_wr = 0; cap_rate_wr = 0;
    chk(int'(req_left_n), int'(m_req_n), {tag, " R2 req_left_n"});
    chk(int'(req_right_n), int'(req_left_n), {tag, " R3 left/right flags equal"});
    chk(int'(cap_valid), int'(fc), {tag, " R4 cap_valid"});
  endtask

  task automatic tick(string tag, output bit fp, output bit fc);
    step(1, 0, 0, 0, 0, tag, fp, fc);
  endtask

  task automatic set_vra(bit v);
    bit a, b;
    vra_en = v;
    step(0, 0, 0, 0, 0, "vra", a, b);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit fp, fc;
    int n;
    void'($urandom(32'd1234));
    m_acc[0] = 0; m_acc[1] = 0; m_rate[0] = 48000; m_rate[1] = 48000; m_req_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(int'(req_left_n), 1, "R1 reset left flag");
    chk(int'(req_right_n), 1, "R1 reset right flag");
    chk(int'(cap_valid), 0, "R1 reset cap_valid");
    for (int i = 0; i < 4; i++) begin
      tick("R1 default", fp, fc);
      chk(int'(fp && fc), 1, "R1 default 48000 fires both");
    end

    // R5: 100 clamps to 4000 -> one request per 12 frames
    step(0, 1, 1, 100, 0, "R5 write", fp, fc);
    n = 0;
    for (int i = 1; i <= 24; i++) begin
      tick("R5", fp, fc);
      chk(int'(fp), (i % 12 == 0) ? 1 : 0, "R5 clamp low pattern");
      if (fc) n++;
    end
    chk(n, 2, "R5 capture clamp low count");

    // R6: over-range clamps to 48000
    step(0, 1, 1, 65535, 50000, "R6 write", fp, fc);
    for (int i = 0; i < 6; i++) begin
      tick("R6", fp, fc);
      chk(int'(fp && fc), 1, "R6 clamp high every frame");
    end

    // R7: fixed rate
    step(0, 1, 1, 8000, 4000, "R7 write", fp, fc);
    tick("R7 pre", fp, fc);
    set_vra(0);
    for (int i = 0; i < 5; i++) begin
      tick("R7", fp, fc);
      chk(int'(fp && fc), 1, "R7 fixed rate fires both");
    end
    set_vra(1);
    n = 0;
    for (int i = 1; i <= 6; i++) begin tick("R7 resume", fp, fc); if (fp) n++; end
    chk(n, 1, "R7 accumulator zero after disable");

    // R8: write coinciding with a tick uses old state, then clears
    step(0, 1, 0, 24000, 0, "R8 w", fp, fc);
    tick("R8 a", fp, fc);
    chk(int'(fp), 0, "R8 half rate first frame");
    step(1, 1, 0, 24000, 0, "R8 coincide", fp, fc);
    chk(int'(fp), 1, "R8 coincident tick uses old accumulator");
    tick("R8 b", fp, fc);
    chk(int'(fp), 0, "R8 accumulator cleared by write");

    // R9: long-run counts
    step(0, 1, 1, 16'h2B11, 16'hAC44, "R9 write", fp, fc);
    n = 0;
    begin
      int nc = 0;
      for (int i = 0; i < 480; i++) begin
        tick("R9", fp, fc);
        if (fp) n++;
        if (fc) nc++;
      end
      chk(n, 480 * 11025 / 48000, "R9 playback count 11025");
      chk(nc, 480 * 44100 / 48000, "R9 capture count 44100");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 31);
      int dp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535) : $urandom_range(4000, 48000);
      int dc = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535) : $urandom_range(4000, 48000);
      if (r == 0) set_vra(!vra_en);
      step(1, r == 1 || r == 3, r == 2 || r == 3, dp, dc, "rand", fp, fc);
      repeat ($urandom_range(0, 2)) step(0, 0, 0, 0, 0, "rand gap", fp, fc);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule